// File: doc/BRIEF.md
# NAND command/address sequencer

This block turns one job descriptor into the pin-level handshake of a raw NAND device: it latches a first command byte, zero to five address bytes, an optional outgoing data burst, an optional second command byte, and then waits for the device to become ready before an optional incoming data burst. Every byte leaves the block with CE# low. CLE or ALE is raised to mark what kind of byte it is, and the device captures the byte on the rising edge of WE#. Incoming bytes are clocked out of the device with RE# pulses.

A controller sets the descriptor fields, pulses `job_valid` while `job_ready` is high, and waits for the one-cycle `job_done` pulse. Typical jobs are a page read (0x00, five address bytes, 0x30, then a read burst), a block erase (0x60, three row bytes, 0xD0), a program load (0x80, five address bytes, a write burst, no second command), followed by a separate confirm job (0x10 alone). All strobe widths, the settle delay before ready/busy is trusted, and the busy timeout are cycle counts held on configuration inputs.

Top module: `nand_seq_top`

## Requirements
- R1: After reset, CE#, WE# and RE# are high, CLE, ALE, `nand_dq_oe`, `job_done`, `rd_valid` and `xfer_done` are low, and `job_ready` is high.
- R2: A job is taken when `job_valid` is high while `job_ready` is high. `job_ready` is low on the next cycle and stays low until the job ends with a single-cycle `job_done` pulse. CE# is high whenever `job_ready` is high.
- R3: The bytes latched by WE# rising edges appear in this order: the first command with CLE high, the address bytes with ALE high, the outgoing data bytes with both low, then the second command with CLE high. CLE and ALE are never high together.
- R4: `job_acyc` selects the address bytes. 0 sends none. 1 sends `job_addr0`. 2 sends three bytes taken from `job_addr_hi` bits [7:0], [15:8] and [23:16], in that order. 3 sends five bytes: first `job_addr0`, then `job_addr_hi` from the least significant byte to the most significant byte.
- R5: The second command byte is sent only when `job_cmd2_en` is 1. Otherwise the value of `job_cmd2` has no effect on the pins.
- R6: Each WE# or RE# low pulse lasts max(`cfg_strobe_lo`,1) cycles. Between two strobes of the same phase, the strobe is high for max(`cfg_strobe_hi`,1) cycles. While WE# is low, `nand_dq_oe` is high and `nand_dq_out` does not change.
- R7: When `job_xfer_en`=1 and `job_xfer_wr`=1, `job_len` bytes are taken from the write stream, one per cycle with `wr_valid` and `wr_ready` both high. They are latched in stream order between the address bytes and the second command. WE# stays high while the stream has no byte to give.
- R8: After the last latched byte, the block ignores `nand_rb` for max(`cfg_wb_wait`,1) cycles and then waits for `nand_rb` to be high. If the device is never busy, `job_done` follows the last WE# rising edge by max(`cfg_strobe_hi`,1) + max(`cfg_wb_wait`,1) + 2 cycles.
- R9: If `nand_rb` stays low for `cfg_busy_tmo` cycles of the ready wait, the job ends with `job_err`=1 in the `job_done` cycle. Otherwise `job_err` is 0, and it is never high without `job_done`.
- R10: When `job_xfer_en`=1 and `job_xfer_wr`=0, the block sends `job_len` RE# pulses once the device is ready, keeping `nand_dq_oe` low. Each pulse yields one `rd_valid` cycle carrying `nand_dq_in` as sampled at the end of the low phase. WE# and RE# are never low together.
- R11: `xfer_done` pulses for one cycle once per job that has a data phase, when that phase completes, and never in a job without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| job_valid | input | 1 | Start request for the descriptor on the job inputs |
| job_ready | output | 1 | Sequencer idle, ready to take a job |
| job_cmd1 | input | 8 | First command byte |
| job_cmd2 | input | 8 | Second command byte |
| job_cmd2_en | input | 1 | Send the second command byte |
| job_acyc | input | 2 | Address byte count code (0 none, 1 one, 2 three, 3 five) |
| job_xfer_en | input | 1 | Job has a data phase |
| job_xfer_wr | input | 1 | Data phase direction, 1 = write to device |
| job_addr0 | input | 8 | Leading address byte |
| job_addr_hi | input | 32 | Further address bytes, least significant first |
| job_len | input | LEN_W | Data phase byte count |
| cfg_strobe_lo | input | TW | WE#/RE# low width in cycles |
| cfg_strobe_hi | input | TW | WE#/RE# high width in cycles |
| cfg_wb_wait | input | TW | Cycles before ready/busy is trusted |
| cfg_busy_tmo | input | TMO_W | Ready wait limit in cycles |
| wr_data | input | 8 | Outgoing data byte |
| wr_valid | input | 1 | Outgoing byte available |
| wr_ready | output | 1 | Outgoing byte taken this cycle if valid |
| rd_data | output | 8 | Incoming data byte |
| rd_valid | output | 1 | `rd_data` valid for this cycle |
| xfer_done | output | 1 | Data phase finished (pulse) |
| job_done | output | 1 | Job finished (pulse) |
| job_err | output | 1 | Ready wait timed out (with `job_done`) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven onto the data bus |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 8 | Byte read from the data bus |
| nand_rb | input | 1 | Ready/busy from the device, low = busy |

## Verification
`job_ready` falls one cycle after the accepting edge. Each WE# or RE# low phase lasts exactly the programmed width in cycles. With an idle device, `job_done` rises a fixed max(hi,1) + max(wb,1) + 2 cycles after the last WE# rise, and this count absorbs the two-stage ready/busy synchroniser. A pin monitor runs on the falling clock edge, which is half a cycle away from every register update. It logs each WE# rising edge together with that cycle's CLE, ALE and bus byte, measures every strobe width, and time-stamps `job_done` and the device's release of ready/busy. The scenario tasks drive inputs one nanosecond after a falling edge and compare the logs and stamps against lists and cycle counts derived from the requirements. Data-phase results are checked only by content and count, because stream stalls and device busy time move them.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_TWB, S_RB, S_RDATA, S_DONE
  } nseq_st_e;

  localparam logic [1:0] AC_NONE  = 2'd0;
  localparam logic [1:0] AC_ONE   = 2'd1;
  localparam logic [1:0] AC_THREE = 2'd2;
  localparam logic [1:0] AC_FIVE  = 2'd3;

  // number of address bytes implied by the count code
  function automatic logic [2:0] addr_beats(input logic [1:0] code);
    case (code)
      AC_NONE:  return 3'd0;
      AC_ONE:   return 3'd1;
      AC_THREE: return 3'd3;
      default:  return 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/nseq_timer.sv
module nseq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt;

  // a load of N gives N cycles before expiry (0 behaves as 1)
  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= (val == '0) ? '0 : val - 1'b1;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/nseq_addr_pick.sv
module nseq_addr_pick
  import nseq_pkg::*;
(
  input  logic [1:0]  code,
  input  logic [2:0]  idx,
  input  logic [7:0]  addr0,
  input  logic [31:0] addr_hi,
  output logic [7:0]  abyte
);
  localparam int LANES = 4;
  logic [7:0] lane [LANES];
  logic [2:0] idx_m1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = addr_hi[8*g +: 8];
  end

  assign idx_m1 = idx - 3'd1;

  always_comb begin
    unique case (code)
      AC_ONE:   abyte = addr0;
      AC_THREE: abyte = lane[idx[1:0]];
      AC_FIVE:  abyte = (idx == 3'd0) ? addr0 : lane[idx_m1[1:0]];
      default:  abyte = 8'h00;
    endcase
  end
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nseq_pkg::*;
#(
  parameter int TW    = 8,
  parameter int TMO_W = 16,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             job_valid,
  output logic             job_ready,
  input  logic [7:0]       job_cmd1,
  input  logic [7:0]       job_cmd2,
  input  logic             job_cmd2_en,
  input  logic [1:0]       job_acyc,
  input  logic             job_xfer_en,
  input  logic             job_xfer_wr,
  input  logic [7:0]       job_addr0,
  input  logic [31:0]      job_addr_hi,
  input  logic [LEN_W-1:0] job_len,
  input  logic [TW-1:0]    cfg_strobe_lo,
  input  logic [TW-1:0]    cfg_strobe_hi,
  input  logic [TW-1:0]    cfg_wb_wait,
  input  logic [TMO_W-1:0] cfg_busy_tmo,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             xfer_done,
  output logic             job_done,
  output logic             job_err,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_out,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_in,
  input  logic             nand_rb
);
  localparam int SYNC = 2;

  nseq_st_e st, st_n, follow, after_addr, after_w;
  logic             lo, lo_n;
  logic [LEN_W-1:0] cnt, cnt_n, lim;
  logic cle_n, ale_n, we_n_n, re_n_n, ce_n_n, oe_n, rdv_n, done_n, err_n, xd_n;
  logic tmo_q, tmo_n, accept;
  logic [7:0] dq_n, rdd_n, byte_val, abyte;
  logic t_load, t_exp, b_load, b_exp;
  logic [TW-1:0] t_val;
  logic [SYNC-1:0] rb_sync;
  logic rb_s;

  // latched descriptor
  logic [7:0]       j_cmd1, j_cmd2, j_a0;
  logic             j_c2en, j_xen, j_xwr;
  logic [1:0]       j_ac;
  logic [31:0]      j_ahi;
  logic [LEN_W-1:0] j_len;

  nseq_timer #(.W(TW)) u_strobe (
    .clk(clk), .rst(rst), .load(t_load), .val(t_val), .expired(t_exp));

  nseq_timer #(.W(TMO_W)) u_busy (
    .clk(clk), .rst(rst), .load(b_load), .val(cfg_busy_tmo), .expired(b_exp));

  nseq_addr_pick u_addr (
    .code(j_ac), .idx(cnt[2:0]), .addr0(j_a0), .addr_hi(j_ahi), .abyte(abyte));

  always_ff @(posedge clk) begin
    if (rst) rb_sync <= '1;
    else     rb_sync <= {rb_sync[SYNC-2:0], nand_rb};
  end
  assign rb_s = rb_sync[SYNC-1];

  assign job_ready  = (st == S_IDLE);
  assign wr_ready   = (st == S_WDATA) && !lo && t_exp && (cnt != j_len);
  assign after_w    = j_c2en ? S_CMD2 : S_TWB;
  assign after_addr = (j_xen && j_xwr) ? S_WDATA : after_w;

  always_comb begin
    unique case (st)
      S_CMD1:  follow = (j_ac != AC_NONE) ? S_ADDR : after_addr;
      S_ADDR:  follow = after_addr;
      S_WDATA: follow = after_w;
      S_CMD2:  follow = S_TWB;
      default: follow = S_DONE;
    endcase
    unique case (st)
      S_CMD1, S_CMD2: lim = LEN_W'(1);
      S_ADDR:         lim = LEN_W'(addr_beats(j_ac));
      default:        lim = j_len;
    endcase
    unique case (st)
      S_CMD1:  byte_val = j_cmd1;
      S_CMD2:  byte_val = j_cmd2;
      S_ADDR:  byte_val = abyte;
      default: byte_val = wr_data;
    endcase
  end

  always_comb begin
    st_n = st; lo_n = lo; cnt_n = cnt;
    cle_n = nand_cle; ale_n = nand_ale; we_n_n = nand_we_n; re_n_n = nand_re_n;
    ce_n_n = nand_ce_n; dq_n = nand_dq_out; oe_n = nand_dq_oe; rdd_n = rd_data;
    rdv_n = 1'b0; done_n = 1'b0; err_n = 1'b0; xd_n = 1'b0; tmo_n = tmo_q;
    t_load = 1'b0; t_val = cfg_strobe_lo; b_load = 1'b0; accept = 1'b0;
    unique case (st)
      S_IDLE: if (job_valid) begin
        accept = 1'b1; st_n = S_CMD1; cnt_n = '0; lo_n = 1'b0;
        ce_n_n = 1'b0; tmo_n = 1'b0;
      end
      S_TWB: if (t_exp) begin
        st_n = S_RB; b_load = 1'b1;
      end
      S_RB: begin
        if (rb_s) begin
          st_n = (j_xen && !j_xwr) ? S_RDATA : S_DONE; cnt_n = '0;
        end else if (b_exp) begin
          tmo_n = 1'b1; st_n = S_DONE;
        end
      end
      S_DONE: begin
        ce_n_n = 1'b1; done_n = 1'b1; err_n = tmo_q; tmo_n = 1'b0; st_n = S_IDLE;
      end
      default: if (t_exp) begin
        if (lo) begin
          // end of strobe low phase: the byte is latched or sampled here
          we_n_n = 1'b1; re_n_n = 1'b1; lo_n = 1'b0; cnt_n = cnt + 1'b1;
          t_load = 1'b1; t_val = cfg_strobe_hi;
          if (st == S_RDATA) begin rdd_n = nand_dq_in; rdv_n = 1'b1; end
        end else begin
          cle_n = 1'b0; ale_n = 1'b0; oe_n = 1'b0;
          if (cnt == lim) begin
            cnt_n = '0; st_n = follow;
            if (follow == S_TWB) begin t_load = 1'b1; t_val = cfg_wb_wait; end
            if (st == S_WDATA || st == S_RDATA) xd_n = 1'b1;
          end else if (st != S_WDATA || wr_valid) begin
            lo_n = 1'b1; t_load = 1'b1; t_val = cfg_strobe_lo;
            if (st == S_RDATA) re_n_n = 1'b0;
            else begin
              we_n_n = 1'b0; oe_n = 1'b1; dq_n = byte_val;
              cle_n = (st == S_CMD1) || (st == S_CMD2);
              ale_n = (st == S_ADDR);
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; lo <= 1'b0; cnt <= '0; tmo_q <= 1'b0;
      nand_ce_n <= 1'b1; nand_cle <= 1'b0; nand_ale <= 1'b0;
      nand_we_n <= 1'b1; nand_re_n <= 1'b1; nand_dq_out <= 8'h00; nand_dq_oe <= 1'b0;
      rd_data <= 8'h00; rd_valid <= 1'b0; xfer_done <= 1'b0;
      job_done <= 1'b0; job_err <= 1'b0;
      j_cmd1 <= '0; j_cmd2 <= '0; j_a0 <= '0; j_c2en <= 1'b0; j_xen <= 1'b0;
      j_xwr <= 1'b0; j_ac <= '0; j_ahi <= '0; j_len <= '0;
    end else begin
      st <= st_n; lo <= lo_n; cnt <= cnt_n; tmo_q <= tmo_n;
      nand_ce_n <= ce_n_n; nand_cle <= cle_n; nand_ale <= ale_n;
      nand_we_n <= we_n_n; nand_re_n <= re_n_n; nand_dq_out <= dq_n; nand_dq_oe <= oe_n;
      rd_data <= rdd_n; rd_valid <= rdv_n; xfer_done <= xd_n;
      job_done <= done_n; job_err <= err_n;
      if (accept) begin
        j_cmd1 <= job_cmd1; j_cmd2 <= job_cmd2; j_a0 <= job_addr0;
        j_c2en <= job_cmd2_en; j_xen <= job_xfer_en; j_xwr <= job_xfer_wr;
        j_ac <= job_acyc; j_ahi <= job_addr_hi; j_len <= job_len;
      end
    end
  end

  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n)); // R10
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !nand_re_n |-> !nand_dq_oe); // R10
  AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |-> nand_dq_oe); // R6
  AST_DQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_out)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    job_done |=> !job_done); // R2
  AST_CE_IDLE: assert property (@(posedge clk) disable iff (rst)
    job_ready |-> nand_ce_n); // R2
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    job_err |-> job_done); // R9
  AST_XFER_PULSE: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done); // R11
endmodule

// File: tb/tb_nand_seq_top.sv
`timescale 1ns/1ps
module tb_nand_seq_top;
  localparam int TW = 8, TMO_W = 16, LEN_W = 10;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic job_valid = 1'b0, job_ready;
  logic [7:0] job_cmd1 = 0, job_cmd2 = 0, job_addr0 = 0;
  logic job_cmd2_en = 0, job_xfer_en = 0, job_xfer_wr = 0;
  logic [1:0] job_acyc = 0;
  logic [31:0] job_addr_hi = 0;
  logic [LEN_W-1:0] job_len = 0;
  logic [TW-1:0] cfg_strobe_lo = 1, cfg_strobe_hi = 1, cfg_wb_wait = 2;
  logic [TMO_W-1:0] cfg_busy_tmo = 1000;
  logic [7:0] wr_data = 0, rd_data, nand_dq_out, nand_dq_in = 0;
  logic wr_valid = 0, wr_ready, rd_valid, xfer_done, job_done, job_err;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic nand_rb = 1'b1;

  nand_seq_top #(.TW(TW), .TMO_W(TMO_W), .LEN_W(LEN_W)) dut (.*);

  int vec_cnt = 0, fail_cnt = 0;
  // scenario knobs (written only by the main initial block)
  int busy_delay = 1, busy_len = 0;
  bit feed_stall = 0;
  // monitor / device model state (written only by the model block)
  int ncyc = 0, nlat = 0, nrd = 0, nxd = 0, ndone = 0;
  int lat_idx = 0, done_idx = 0, rb_rel = 0, strobe_bad = 0;
  bit done_err = 0;
  logic [1:0] lat_k [64];
  logic [7:0] lat_b [64];
  logic [7:0] rd_log [64];
  int pend = 0, busy_left = 0, ridx = 0, wr_idx = 0, run = 0;
  bit consume = 0, prev_we = 1, prev_re = 1;
  logic [7:0] prev_dq = 0;
  // expectations
  int ne = 0;
  logic [1:0] exp_k [64];
  logic [7:0] exp_b [64];

  always @(negedge clk) begin
    int exp_lo;
    exp_lo = (cfg_strobe_lo == 0) ? 1 : int'(cfg_strobe_lo);
    ncyc++;
    if (job_valid) begin nlat = 0; nrd = 0; nxd = 0; ridx = 0; wr_idx = 0; consume = 0; end
    // ready/busy behaviour of the device
    if (pend > 0) begin pend--; if (pend == 0) busy_left = busy_len; end
    if (busy_left > 0) begin nand_rb = 1'b0; busy_left--; end
    else begin if (!nand_rb) rb_rel = ncyc; nand_rb = 1'b1; end
    // write strobe monitor
    if (!nand_we_n) begin
      run++;
      if (!prev_we && nand_dq_out != prev_dq) strobe_bad++;
    end
    if (!prev_we && nand_we_n) begin
      if (run != exp_lo) strobe_bad++;
      run = 0;
      if (nlat < 64) begin
        lat_k[nlat] = {nand_ale, nand_cle};
        lat_b[nlat] = nand_dq_out;
        nlat++;
      end
      lat_idx = ncyc;
      if (nand_cle && busy_len > 0 && (nand_dq_out == 8'h30 || nand_dq_out == 8'hD0 ||
          nand_dq_out == 8'h10 || nand_dq_out == 8'hFF))
        pend = busy_delay + 1;
    end
    // read strobe and device output
    if (!nand_re_n) begin run++; nand_dq_in = 8'h50 + 8'(ridx); end
    if (!prev_re && nand_re_n) begin
      if (run != exp_lo) strobe_bad++;
      run = 0; ridx++;
    end
    prev_we = nand_we_n; prev_re = nand_re_n; prev_dq = nand_dq_out;
    if (rd_valid && nrd < 64) begin rd_log[nrd] = rd_data; nrd++; end
    if (xfer_done) nxd++;
    if (job_done) begin ndone++; done_idx = ncyc; done_err = job_err; end
    // write stream feeder
    if (consume) wr_idx++;
    wr_valid = !(feed_stall && (ncyc % 3 != 0));
    wr_data  = 8'hC0 + 8'(wr_idx);
    consume  = wr_valid && wr_ready;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] b);
    exp_k[ne] = k; exp_b[ne] = b; ne++;
  endtask

  task automatic cmp_lat(input string req);
    chk(nlat == ne, {req, " latch count"}, nlat, ne);
    for (int i = 0; i < ne && i < nlat; i++)
      chk({lat_k[i], lat_b[i]} == {exp_k[i], exp_b[i]}, {req, " latched byte"},
          {lat_k[i], lat_b[i]}, {exp_k[i], exp_b[i]});
  endtask

  task automatic run_job(input logic [7:0] c1, input logic [7:0] c2, input bit c2en,
                         input logic [1:0] ac, input bit xen, input bit xwr,
                         input logic [7:0] a0, input logic [31:0] ahi, input int len);
    int start;
    @(negedge clk); #1;
    job_cmd1 = c1; job_cmd2 = c2; job_cmd2_en = c2en; job_acyc = ac;
    job_xfer_en = xen; job_xfer_wr = xwr; job_addr0 = a0; job_addr_hi = ahi;
    job_len = LEN_W'(len); job_valid = 1'b1;
    start = ndone;
    @(negedge clk); #1;
    chk(job_ready == 1'b0, "R2 ready drops after accept", job_ready, 0);
    job_valid = 1'b0;
    for (int i = 0; i < 5000 && ndone == start; i++) begin @(negedge clk); #1; end
    chk(ndone == start + 1, "R2 job_done seen", ndone - start, 1);
    @(negedge clk); #1;
    chk(job_ready == 1'b1, "R2 ready after done", job_ready, 1);
    ne = 0;
  endtask

  task automatic t_reset;
    // R1
    chk(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes idle high",
        {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
    chk(!nand_cle && !nand_ale && !nand_dq_oe, "R1 latches and drive low",
        {nand_cle, nand_ale, nand_dq_oe}, 0);
    chk(job_ready && !job_done && !rd_valid && !xfer_done, "R1 status",
        {job_ready, job_done, rd_valid, xfer_done}, 4'b1000);
  endtask

  task automatic t_page_read;
    // R3 R4 (five) R5 R10 R11
    busy_delay = 1; busy_len = 8;
    run_job(8'h00, 8'h30, 1, 2'd3, 1, 0, 8'h12, 32'h44332211, 4);
    push(1, 8'h00); push(2, 8'h12); push(2, 8'h11); push(2, 8'h22); push(2, 8'h33); push(2, 8'h44);
    push(1, 8'h30);
    cmp_lat("R3 R4 page read order");
    chk(nrd == 4, "R10 read byte count", nrd, 4);
    for (int i = 0; i < 4 && i < nrd; i++)
      chk(rd_log[i] == 8'h50 + 8'(i), "R10 read data", rd_log[i], 8'h50 + i);
    chk(nxd == 1, "R11 xfer_done once", nxd, 1);
    chk(done_err == 0, "R9 no error", done_err, 0);
  endtask

  task automatic t_erase;
    // R4 three bytes, R11 no data phase
    busy_delay = 2; busy_len = 6;
    run_job(8'h60, 8'hD0, 1, 2'd2, 0, 0, 8'h99, 32'h00ABCDEF, 0);
    push(1, 8'h60); push(2, 8'hEF); push(2, 8'hCD); push(2, 8'hAB); push(1, 8'hD0);
    cmp_lat("R4 erase three address bytes");
    chk(nxd == 0, "R11 no xfer_done without data phase", nxd, 0);
  endtask

  task automatic t_read_id;
    // R4 one byte, R5 second command suppressed
    busy_len = 0;
    run_job(8'h90, 8'h77, 0, 2'd1, 1, 0, 8'h5A, 32'hFFFFFFFF, 2);
    push(1, 8'h90); push(2, 8'h5A);
    cmp_lat("R4 R5 one address byte, no second command");
    chk(nrd == 2, "R10 id bytes", nrd, 2);
  endtask

  task automatic t_program;
    // R7 stalled stream, R5 no confirm in load job, R4 none in confirm job
    busy_len = 0; feed_stall = 1;
    run_job(8'h80, 8'h10, 0, 2'd3, 1, 1, 8'h01, 32'h00030201, 3);
    push(1, 8'h80); push(2, 8'h01); push(2, 8'h01); push(2, 8'h02); push(2, 8'h03); push(2, 8'h00);
    push(0, 8'hC0); push(0, 8'hC1); push(0, 8'hC2);
    cmp_lat("R7 program load with stalls");
    chk(nxd == 1, "R11 write phase done once", nxd, 1);
    feed_stall = 0; busy_delay = 1; busy_len = 5;
    run_job(8'h10, 8'h00, 0, 2'd0, 0, 0, 8'hAA, 32'h12345678, 0);
    push(1, 8'h10);
    cmp_lat("R4 confirm without address");
  endtask

  task automatic t_wide_strobes;
    // R3 data before second command, R6 strobe widths
    cfg_strobe_lo = 3; cfg_strobe_hi = 2; busy_len = 0;
    run_job(8'h85, 8'h10, 1, 2'd3, 1, 1, 8'h07, 32'h0A090807, 2);
    push(1, 8'h85); push(2, 8'h07); push(2, 8'h07); push(2, 8'h08); push(2, 8'h09); push(2, 8'h0A);
    push(0, 8'hC0); push(0, 8'hC1); push(1, 8'h10);
    cmp_lat("R3 data between address and second command");
    chk(strobe_bad == 0, "R6 strobe widths and bus hold", strobe_bad, 0);
    cfg_strobe_lo = 1; cfg_strobe_hi = 1;
  endtask

  task automatic t_settle;
    // R8 exact completion latency with an idle device
    busy_len = 0; cfg_strobe_hi = 2; cfg_wb_wait = 5;
    run_job(8'hFF, 8'h00, 0, 2'd0, 0, 0, 8'h00, 32'h0, 0);
    chk(done_idx - lat_idx == 9, "R8 done latency hi+wb+2", done_idx - lat_idx, 9);
    // R8 late busy must not be missed when the settle window covers it
    cfg_strobe_hi = 1; cfg_wb_wait = 10; busy_delay = 3; busy_len = 20;
    run_job(8'hFF, 8'h00, 0, 2'd0, 0, 0, 8'h00, 32'h0, 0);
    chk(done_idx > rb_rel, "R8 waits for late busy release", done_idx, rb_rel);
    cfg_wb_wait = 2;
  endtask

  task automatic t_timeout;
    // R9
    cfg_busy_tmo = 30; busy_delay = 0; busy_len = 200;
    run_job(8'h60, 8'hD0, 1, 2'd2, 0, 0, 8'h00, 32'h000102, 0);
    chk(done_err == 1, "R9 timeout flagged", done_err, 1);
    chk(done_idx < rb_rel || !nand_rb, "R9 ended while busy", done_idx, rb_rel);
    repeat (220) @(negedge clk);
    #1;
    busy_len = 4; cfg_busy_tmo = 1000;
    run_job(8'h60, 8'hD0, 1, 2'd2, 0, 0, 8'h00, 32'h000102, 0);
    chk(done_err == 0, "R9 error clears on next job", done_err, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    t_reset();
    t_page_read();
    t_erase();
    t_read_id();
    t_program();
    t_wide_strobes();
    t_settle();
    t_timeout();
    chk(strobe_bad == 0, "R6 all strobes in run", strobe_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt + 1, fail_cnt + 1);
    $finish;
  end
endmodule